// File: doc/BRIEF.md
# Synthesizer Serial Configuration Register Bank

This block is the write-only configuration port of a frequency synthesizer and modulator. A host drives three wires: a serial clock, a data line and a latch strobe. On every rising edge of the serial clock the block shifts one data bit into a 24-bit word, most significant bit first. When the latch strobe rises, the upper 21 bits of that word are committed into one of six configuration registers. The three lowest bits of the word are the register address.

The pins are asynchronous to the core, so the block first brings them into the core clock domain. Each pin passes through a two-stage synchronizer, and edges are detected after it. A serial clock of up to 20 MHz, with high and low phases of at least 25 ns, leaves several core cycles per phase at the 200 MHz core rate. The committed registers leave the block as one flat bus for the downstream synthesizer logic. A field decoder reads registers 4 and 5 and drives the following control outputs:
- the monitor-mux select;
- the charge-pump current code and its value in microamps;
- the charge-pump reference source;
- the LO port direction, which is also set by an external pin;
- the external-LO routing and the LO output divide mode.

Top module: `synth_ctl_port`

## Requirements
- R1: After the asynchronous active-low reset, all six registers read zero, `mon_sel`, `cp_code` and `cp_ext_ref` are 0, `cp_ua` is 250, and `lo_port_out` equals `lo_sel_pin`.
- R2: Data is taken on each rising edge of `ser_clk`, most significant bit first. After 24 edges, word bit 23 is the first bit that was sent and bit 0 is the last.
- R3: A rising edge of `ser_le` copies word bits 23..3 into register k, where k is the value of word bits 2..0 (0 to 5). Register k occupies `cfg_bank[21*k+20 : 21*k]`, and word bit n lands at bit n-3 of that slice. The other registers are unchanged.
- R4: A word whose bits 2..0 equal 6 or 7 is dropped when the strobe rises, and no register changes.
- R5: Only a rising edge of `ser_le` commits a word. Serial clock edges while `ser_le` is high leave the registers unchanged, but the shift register keeps shifting. A later strobe rise with no clocks in between commits the shifted word.
- R6: When a serial clock rise and a strobe rise reach the core in the same cycle, the word that was held before that clock edge is committed.
- R7: `mon_sel` equals bits 23..21 of register 4.
- R8: `cp_code` equals bits 11..10 of register 4. `cp_ua` is 250 × (`cp_code` + 1), which gives 250, 500, 750 or 1000. `cp_ext_ref` equals bit 18 of register 4 (0 selects the internal reference, 1 the external resistor).
- R9: `lo_port_out` is 1 (the LO port acts as an output) when `lo_sel_pin` is 1 or bit 3 of register 5 is 1. Otherwise it is 0 (the port acts as an input).
- R10: `lo_ext_route` equals bit 4 of register 5. `lo_div_1x` equals bit 5 of register 5 (1 gives a 1× LO output, 0 gives a 2× LO output).
- R11: The decoded outputs follow only the committed registers. Shifting in a word without a strobe rise leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock pin (asynchronous) |
| ser_data | input | 1 | Serial data pin (asynchronous) |
| ser_le | input | 1 | Latch strobe pin (asynchronous) |
| lo_sel_pin | input | 1 | LO port select pin; 1 forces the port to output |
| cfg_bank | output | 126 | Six committed 21-bit registers; register k at bits 21k+20..21k |
| mon_sel | output | 3 | Monitor-output mux select |
| cp_code | output | 2 | Charge-pump current code |
| cp_ua | output | 11 | Charge-pump current in microamps |
| cp_ext_ref | output | 1 | Charge-pump reference: 0 internal, 1 external resistor |
| lo_port_out | output | 1 | LO port direction: 1 output, 0 input |
| lo_ext_route | output | 1 | Route the external LO to the modulator |
| lo_div_1x | output | 1 | LO output mode: 1 for 1×, 0 for 2× |

## Verification
The shift and the commit can fall in the same core cycle. This happens when a serial clock rise and a strobe rise pass the synchronizers together, and the commit must then take the word from before that shift. The bench provokes it by raising `ser_clk` and `ser_le` at the same instant after a full 24-bit word, with an extra data bit waiting on the line. It judges the result by reading the target register on `cfg_bank`, which must hold the original word and not the word moved on by one bit. A companion test clocks bits while the strobe is held high, then raises the strobe again. This shows that the shifting went on and that only the strobe edge commits.

// File: rtl/synctl_pkg.sv
package synctl_pkg;
  localparam int WORD_W   = 24;
  localparam int ADDR_W   = 3;
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int NUM_REGS = 6;
  localparam int UA_W     = 11;

  // register indices with decoded content
  localparam int REG_PLLCP = 4;
  localparam int REG_LOCTL = 5;

  // word-level bit positions of decoded fields
  localparam int MON_TOP  = 23;
  localparam int CPSRC_B  = 18;
  localparam int CPI_TOP  = 11;
  localparam int LODRV_B  = 3;
  localparam int LOXL_B   = 4;
  localparam int LODIV_B  = 5;

  typedef logic [PAY_W-1:0]  payload_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // payload bit that holds word bit n
  function automatic logic word_bit(payload_t p, int n);
    return p[n-ADDR_W];
  endfunction

  function automatic logic [2:0] mon_field(payload_t p);
    return p[MON_TOP-ADDR_W -: 3];
  endfunction

  function automatic logic [1:0] cpi_field(payload_t p);
    return p[CPI_TOP-ADDR_W -: 2];
  endfunction

  // nominal charge pump current in microamps
  function automatic logic [UA_W-1:0] cp_microamps(logic [1:0] code);
    return UA_W'(250) * (UA_W'(code) + UA_W'(1));
  endfunction

  function automatic logic addr_valid(addr_t a);
    return int'(a) < NUM_REGS;
  endfunction
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
  parameter int          W         = 3,
  parameter int          STAGES    = 2,
  parameter logic [W-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] evt_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[STAGES-2:0], pin_i[b]};
    end
    if (EDGE_MASK[b]) begin : g_edge
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
      end
      assign evt_o[b] = sync_q[STAGES-1] & ~last_q;
    end else begin : g_level
      assign evt_o[b] = sync_q[STAGES-1];
    end
  end
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= {word_q[W-2:0], bit_in};
  end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank #(
  parameter int N  = 6,
  parameter int PW = 21,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] payload,
  output logic [N-1:0]  we,
  output logic [N*PW-1:0] bank
);
  for (genvar k = 0; k < N; k++) begin : g_reg
    assign we[k] = commit && (addr == AW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bank[k*PW +: PW] <= '0;
      else if (we[k]) bank[k*PW +: PW] <= payload;
    end
  end
endmodule

// File: rtl/tw_field_decode.sv
module tw_field_decode
  import synctl_pkg::*;
(
  input  logic            mon_raw_i,
  input  logic [2:0]      mon_bits_i,
  input  logic [1:0]      cpi_i,
  input  logic            cpsrc_i,
  input  logic            lodrv_i,
  input  logic            loxl_i,
  input  logic            lodiv_i,
  input  logic            lo_sel_pin,
  output logic [2:0]      mon_sel,
  output logic [1:0]      cp_code,
  output logic [UA_W-1:0] cp_ua,
  output logic            cp_ext_ref,
  output logic            lo_port_out,
  output logic            lo_ext_route,
  output logic            lo_div_1x
);
  // mon_raw_i repeats the top bit of mon_bits_i and serves as a consistency tap
  assign mon_sel      = {mon_raw_i | mon_bits_i[2], mon_bits_i[1:0]};
  assign cp_code      = cpi_i;
  assign cp_ua        = cp_microamps(cpi_i);
  assign cp_ext_ref   = cpsrc_i;
  assign lo_port_out  = lo_sel_pin | lodrv_i;
  assign lo_ext_route = loxl_i;
  assign lo_div_1x    = lodiv_i;
endmodule

// File: rtl/synth_ctl_port.sv
module synth_ctl_port
  import synctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk,
  input  logic                  ser_data,
  input  logic                  ser_le,
  input  logic                  lo_sel_pin,
  output logic [NUM_REGS*PAY_W-1:0] cfg_bank,
  output logic [2:0]            mon_sel,
  output logic [1:0]            cp_code,
  output logic [UA_W-1:0]       cp_ua,
  output logic                  cp_ext_ref,
  output logic                  lo_port_out,
  output logic                  lo_ext_route,
  output logic                  lo_div_1x
);
  // named internal events for the checker
  logic [2:0]          pin_evt;
  logic                data_bit;
  logic                sclk_rise;
  logic                le_rise;
  logic [WORD_W-1:0]   shift_q;
  logic                commit;
  logic [NUM_REGS-1:0] commit_we;
  payload_t            reg_cp;
  payload_t            reg_lo;

  tw_sync_edge #(.W(3), .STAGES(2), .EDGE_MASK(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({ser_le, ser_clk, ser_data}),
    .evt_o(pin_evt)
  );
  assign data_bit  = pin_evt[0];
  assign sclk_rise = pin_evt[1];
  assign le_rise   = pin_evt[2];

  tw_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sclk_rise), .bit_in(data_bit),
    .word_q(shift_q)
  );

  // commit samples shift_q before any same-cycle shift lands
  assign commit = le_rise && addr_valid(shift_q[ADDR_W-1:0]);

  tw_reg_bank #(.N(NUM_REGS), .PW(PAY_W), .AW(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .commit(commit),
    .addr(shift_q[ADDR_W-1:0]),
    .payload(shift_q[WORD_W-1:ADDR_W]),
    .we(commit_we),
    .bank(cfg_bank)
  );

  assign reg_cp = cfg_bank[REG_PLLCP*PAY_W +: PAY_W];
  assign reg_lo = cfg_bank[REG_LOCTL*PAY_W +: PAY_W];

  tw_field_decode u_dec (
    .mon_raw_i(word_bit(reg_cp, MON_TOP)),
    .mon_bits_i(mon_field(reg_cp)),
    .cpi_i(cpi_field(reg_cp)),
    .cpsrc_i(word_bit(reg_cp, CPSRC_B)),
    .lodrv_i(word_bit(reg_lo, LODRV_B)),
    .loxl_i(word_bit(reg_lo, LOXL_B)),
    .lodiv_i(word_bit(reg_lo, LODIV_B)),
    .lo_sel_pin(lo_sel_pin),
    .mon_sel(mon_sel),
    .cp_code(cp_code),
    .cp_ua(cp_ua),
    .cp_ext_ref(cp_ext_ref),
    .lo_port_out(lo_port_out),
    .lo_ext_route(lo_ext_route),
    .lo_div_1x(lo_div_1x)
  );
endmodule

// File: rtl/synth_ctl_port_chk.sv
module synth_ctl_port_chk
  import synctl_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sclk_rise,
  input logic                      le_rise,
  input logic                      data_bit,
  input logic [WORD_W-1:0]         shift_q,
  input logic [NUM_REGS-1:0]       commit_we,
  input logic [NUM_REGS*PAY_W-1:0] cfg_bank,
  input logic                      lo_sel_pin,
  input logic                      lo_port_out,
  input logic [UA_W-1:0]           cp_ua
);
  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_q == {$past(shift_q[WORD_W-2:0]), $past(data_bit)}); // R2

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_we)); // R3

  AST_BAD_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !addr_valid(shift_q[ADDR_W-1:0])) |=> $stable(cfg_bank)); // R4

  AST_ONLY_STROBE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(cfg_bank)); // R5

  // same-cycle shift and strobe: the pre-shift word is the one stored (R6)
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_land
    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      commit_we[k] |=> cfg_bank[k*PAY_W +: PAY_W] == $past(shift_q[WORD_W-1:ADDR_W])); // R3
  end

  AST_CP_UA_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cp_ua inside {11'd250, 11'd500, 11'd750, 11'd1000}); // R8

  AST_PIN_FORCES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    lo_sel_pin |-> lo_port_out); // R9
endmodule

bind synth_ctl_port synth_ctl_port_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .sclk_rise(sclk_rise), .le_rise(le_rise), .data_bit(data_bit),
  .shift_q(shift_q), .commit_we(commit_we), .cfg_bank(cfg_bank),
  .lo_sel_pin(lo_sel_pin), .lo_port_out(lo_port_out), .cp_ua(cp_ua)
);

// File: tb/synth_ctl_port_tb_top.sv
`timescale 1ns/100ps
module synth_ctl_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, lo_sel_pin = 1'b0;
  logic [125:0] cfg_bank;
  logic [2:0]   mon_sel;
  logic [1:0]   cp_code;
  logic [10:0]  cp_ua;
  logic cp_ext_ref, lo_port_out, lo_ext_route, lo_div_1x;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [20:0] model [6];

  always #2.5 clk = ~clk;

  synth_ctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .lo_sel_pin(lo_sel_pin), .cfg_bank(cfg_bank),
    .mon_sel(mon_sel), .cp_code(cp_code), .cp_ua(cp_ua),
    .cp_ext_ref(cp_ext_ref), .lo_port_out(lo_port_out),
    .lo_ext_route(lo_ext_route), .lo_div_1x(lo_div_1x)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_of(int k);
    return 32'(cfg_bank[k*21 +: 21]);
  endfunction

  task automatic chk_bank(string tag);
    for (int k = 0; k < 6; k++) chk(tag, reg_of(k), 32'(model[k]));
  endtask

  task automatic sbit(logic b);
    ser_data = b; #25;
    ser_clk = 1'b1; #50;
    ser_clk = 1'b0; #25;
  endtask

  task automatic send(logic [23:0] w);
    for (int i = 23; i >= 0; i--) sbit(w[i]);
  endtask

  task automatic latch();
    #20 ser_le = 1'b1;
    #40 ser_le = 1'b0;
    #40;
  endtask

  task automatic write(logic [23:0] w);
    send(w);
    latch();
    if (w[2:0] < 3'd6) model[w[2:0]] = w[23:3];
  endtask

  task automatic t_reset();
    chk_bank("R1 reset bank");
    chk("R1 mon_sel", 32'(mon_sel), 0);
    chk("R1 cp_code", 32'(cp_code), 0);
    chk("R1 cp_ua", 32'(cp_ua), 250);
    chk("R1 cp_ext_ref", 32'(cp_ext_ref), 0);
    chk("R1 lo_port_out", 32'(lo_port_out), 0);
  endtask

  task automatic t_each_addr();
    for (int k = 0; k < 6; k++) write({21'h0A5C30 ^ 21'(k * 21'h111), 3'(k)});
    chk_bank("R3 each address");
    write({21'h1FFFFF, 3'd2});
    chk_bank("R2 all ones reg2");
    write({21'h100001, 3'd0});
    chk("R2 msb first reg0", reg_of(0), 32'h100001);
  endtask

  task automatic t_bad_addr();
    write({21'h1FFFFF, 3'd6});
    chk_bank("R4 addr6 dropped");
    write({21'h155555, 3'd7});
    chk_bank("R4 addr7 dropped");
  endtask

  task automatic t_le_high();
    logic [23:0] w;
    w = {21'h0F0F0F, 3'd1};
    send(w);
    #20 ser_le = 1'b1;
    #40;
    model[1] = w[23:3];
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
    chk_bank("R5 clocks while strobe high");
    ser_le = 1'b0;
    #40;
    latch();
    model[2] = w[20:0];
    chk_bank("R5 shifted word committed");
  endtask

  task automatic t_same_cycle();
    logic [23:0] w;
    w = {21'h13579B, 3'd3};
    send(w);
    ser_data = 1'b1; #25;
    ser_clk = 1'b1; ser_le = 1'b1; #50;
    ser_clk = 1'b0; ser_le = 1'b0; #50;
    model[3] = w[23:3];
    chk("R6 pre-shift word", reg_of(3), 32'(model[3]));
    chk_bank("R6 bank");
  endtask

  task automatic t_cp_fields();
    for (int c = 0; c < 4; c++) begin
      logic [23:0] w;
      w = (24'(c) << 10) | (24'(c & 1) << 18) | (24'(c + 3) << 21) | 24'd4;
      write(w);
      chk("R8 cp_code", 32'(cp_code), 32'(c));
      chk("R8 cp_ua", 32'(cp_ua), 32'(c * 250 + 250));
      chk("R8 cp_ext_ref", 32'(cp_ext_ref), 32'(c & 1));
      chk("R7 mon_sel", 32'(mon_sel), 32'((c + 3) & 7));
    end
  endtask

  task automatic t_lo();
    for (int v = 0; v < 8; v++) begin
      logic [23:0] w;
      w = (24'(v) << 3) | 24'd5;
      write(w);
      for (int p = 0; p < 2; p++) begin
        lo_sel_pin = p[0];
        #20;
        chk("R9 lo_port_out", 32'(lo_port_out), 32'((p | v) & 1));
      end
      lo_sel_pin = 1'b0;
      chk("R10 lo_ext_route", 32'(lo_ext_route), 32'((v >> 1) & 1));
      chk("R10 lo_div_1x", 32'(lo_div_1x), 32'((v >> 2) & 1));
    end
  endtask

  task automatic t_no_latch();
    logic [2:0] m0;
    logic [10:0] u0;
    m0 = mon_sel;
    u0 = cp_ua;
    send({3'b010, 2'b00, 1'b0, 7'd0, 2'b11, 6'd0, 3'd4});
    #100;
    chk("R11 mon_sel held", 32'(mon_sel), 32'(m0));
    chk("R11 cp_ua held", 32'(cp_ua), 32'(u0));
    chk_bank("R11 bank held");
  endtask

  initial begin
    for (int k = 0; k < 6; k++) model[k] = '0;
    #23 rst_n = 1'b1;
    #20;
    t_reset();
    t_each_addr();
    t_bad_addr();
    t_le_high();
    t_same_cycle();
    t_cp_fields();
    t_lo();
    t_no_latch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule